// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets a host reach the management registers of an Ethernet PHY through a single 32-bit command/status word. The host writes one word that holds the operation, the PHY address, the PHY register number and, for a write, the 16-bit payload. The controller then produces the complete serial management frame on the MDC clock and MDIO data pins. No further host action is needed until the frame has finished.

When the frame ends, the controller sets a ready flag in the same word. For a read, it also places the 16 bits returned by the PHY in the word's data field. If the host set the interrupt-enable bit in the command, an interrupt line goes high at completion and stays high until the next command is written. A host can therefore poll the ready bit, wait for the interrupt, or do both.

MDC is derived from the system clock by a parameterised divider. The default divider of 10 gives 5 MHz MDC from a 100 MHz clock, so a 64-bit frame takes 12.8 µs, well inside the 64 µs budget for one transaction.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The command word reads back with data in bits 15:0, PHY register number in bits 20:16, PHY address in bits 25:21, operation in bits 27:26, ready in bit 28 and interrupt enable in bit 29. Bits 31:30 always read 0, and the whole word reads 0 after reset.
- R2: Operation code 01 is a write. It sends PRE_LEN ones, then 01, then 01, then the 5-bit PHY address, then the 5-bit register number, then turnaround 10, then the 16 data bits. All fields go MSB first, and MDIO is driven for every bit.
- R3: Operation code 10 is a read. It sends PRE_LEN ones, then 01, then 10, then the PHY address, then the register number, and then releases MDIO (mdio_oe low) for the turnaround and the data bits. The 16 bits sampled in the data phase, MSB first, appear in bits 15:0 when the read completes.
- R4: An accepted command write with a valid operation clears ready in the next cycle. Ready is set in the cycle the frame completes.
- R5: When the command had interrupt enable set, irq rises together with ready. irq holds until the next accepted command write and then drops. irq stays low when interrupt enable was 0.
- R6: A command with operation code 00 or 11 produces no MDC edge and no frame. It stores its fields and sets ready in the cycle after the write. With interrupt enable set, it also raises irq.
- R7: A register write that arrives while a frame is in progress is ignored. The frame on the pins and the fields read back are those of the earlier command.
- R8: MDC stays low while idle and toggles every HALF_DIV clock cycles during a frame. A frame completes exactly (PRE_LEN+32)·2·HALF_DIV cycles after the accepting write edge.
- R9: MDIO output data changes only on the clock edge where MDC falls, or at the start of a frame. Read data is sampled on the clock edge where MDC rises.
- R10: After reset, mdc, mdio_oe and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word written by the host |
| reg_rdata | output | 32 | Command/status word read back |
| irq | output | 1 | Completion interrupt, level |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven to the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data from the PHY |

## Verification
The bench runs sweeps of write and read commands over spread-out PHY addresses, register numbers and data values. For each command it compares every bit seen on MDIO against the arithmetic frame, and it compares the completion cycle against the closed-form length. A wrong field order or bit count shows up as a bad frame, and an off-by-one in the divider or bit counter shows up as a shifted completion cycle. Commands with a reserved operation are checked for an immediate ready and for no MDC activity; a design that ran them would toggle MDC or leave ready low. A second command written mid-frame is checked not to disturb the pins or the fields read back. Interrupt checks cover holding irq after completion and dropping it on the next command write.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   typedef enum logic [1:0] {
      MOP_RSV_LO = 2'b00,
      MOP_WRITE  = 2'b01,
      MOP_READ   = 2'b10,
      MOP_RSV_HI = 2'b11
   } mgmt_op_e;

   localparam int ADDR_W    = 5;
   localparam int DATA_W    = 16;
   localparam int RNUM_LSB  = 16;
   localparam int PADDR_LSB = 21;
   localparam int OP_LSB    = 26;
   localparam int READY_BIT = 28;
   localparam int IEN_BIT   = 29;

   typedef struct packed {
      logic              ien;
      mgmt_op_e          op;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] rnum;
      logic [DATA_W-1:0] data;
   } mgmt_cmd_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int HALF_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise,
   output logic fall
);

   logic tick;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end

      if (HALF_DIV == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_counter
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (!run)       cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == LAST);

         AST_DIV_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> cnt == '0);   // R8
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mdc <= 1'b0;
      else if (!run) mdc <= 1'b0;
      else if (tick) mdc <= ~mdc;
   end

   assign rise = tick & ~mdc;
   assign fall = tick &  mdc;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  mgmt_op_e          start_op,
   input  logic [ADDR_W-1:0] start_phy,
   input  logic [ADDR_W-1:0] start_rnum,
   input  logic [DATA_W-1:0] start_data,
   input  logic              rise,
   input  logic              fall,
   input  logic              mdio_i,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_data,
   output logic              mdio_o,
   output logic              mdio_oe
);

   localparam int NBITS = PRE_LEN + 32;
   localparam int IW    = $clog2(NBITS);
   localparam logic [IW-1:0] LAST_IDX = IW'(NBITS - 1);
   localparam logic [IW-1:0] TA_IDX   = IW'(PRE_LEN + 14);
   localparam logic [IW-1:0] RX_IDX   = IW'(PRE_LEN + 16);

   generate
      if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
         $error("PRE_LEN must lie in 1..64");
      end
   endgenerate

   logic [NBITS-1:0] tx_sr;
   logic [IW-1:0]    idx;
   logic             is_rd;

   assign done    = busy && fall && (idx == LAST_IDX);
   assign mdio_o  = busy & tx_sr[NBITS-1];
   assign mdio_oe = busy && (!is_rd || (idx < TA_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx   <= '0;
         is_rd <= 1'b0;
         tx_sr <= '0;
      end else if (start && !busy) begin
         busy  <= 1'b1;
         idx   <= '0;
         is_rd <= (start_op == MOP_READ);
         tx_sr <= {{PRE_LEN{1'b1}}, 2'b01, start_op, start_phy, start_rnum,
                   2'b10, start_data};
      end else if (busy && fall) begin
         if (idx == LAST_IDX) begin
            busy <= 1'b0;
         end else begin
            idx   <= idx + 1'b1;
            tx_sr <= {tx_sr[NBITS-2:0], 1'b0};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_data <= '0;
      else if (busy && rise && is_rd && (idx >= RX_IDX))
         rx_data <= {rx_data[DATA_W-2:0], mdio_i};
   end

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> idx <= LAST_IDX);   // R2

   AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && is_rd && $past(busy) && !$past(mdio_oe)) |-> !mdio_oe);   // R3

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_mgmt_pkg::*;
#(
   parameter int HALF_DIV = 10,
   parameter int PRE_LEN  = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);

   mgmt_cmd_t         cmd_q;
   mgmt_cmd_t         cmd_in;
   logic              ready_q;
   logic              busy;
   logic              done;
   logic              mdc_rise;
   logic              mdc_fall;
   logic [DATA_W-1:0] rx_data;
   logic              accept;
   logic              op_valid;

   assign cmd_in.ien  = reg_wdata[IEN_BIT];
   assign cmd_in.op   = mgmt_op_e'(reg_wdata[OP_LSB +: 2]);
   assign cmd_in.phy  = reg_wdata[PADDR_LSB +: ADDR_W];
   assign cmd_in.rnum = reg_wdata[RNUM_LSB +: ADDR_W];
   assign cmd_in.data = reg_wdata[DATA_W-1:0];

   assign accept   = reg_wr && !busy;
   assign op_valid = (cmd_in.op == MOP_WRITE) || (cmd_in.op == MOP_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         ready_q <= 1'b0;
         irq     <= 1'b0;
      end else if (accept) begin
         cmd_q   <= cmd_in;
         ready_q <= !op_valid;
         irq     <= !op_valid && cmd_in.ien;
      end else if (done) begin
         ready_q <= 1'b1;
         irq     <= cmd_q.ien;
         if (cmd_q.op == MOP_READ) cmd_q.data <= rx_data;
      end
   end

   assign reg_rdata = {2'b00, cmd_q.ien, ready_q, cmd_q.op, cmd_q.phy,
                       cmd_q.rnum, cmd_q.data};

   mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .mdc  (mdc),
      .rise (mdc_rise),
      .fall (mdc_fall)
   );

   mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept && op_valid),
      .start_op  (cmd_in.op),
      .start_phy (cmd_in.phy),
      .start_rnum(cmd_in.rnum),
      .start_data(cmd_in.data),
      .rise      (mdc_rise),
      .fall      (mdc_fall),
      .mdio_i    (mdio_i),
      .busy      (busy),
      .done      (done),
      .rx_data   (rx_data),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe)
   );

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));   // R8

   AST_READY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !busy && op_valid) |=> (!reg_rdata[READY_BIT] && busy));   // R4

   AST_RSV_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !busy && !op_valid) |=> (reg_rdata[READY_BIT] && !busy));   // R6

   AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && busy && !done) |=> $stable({reg_rdata[IEN_BIT], reg_rdata[27:16]}));   // R7

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !reg_wr) |=> irq);   // R5

   AST_IRQ_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> reg_rdata[READY_BIT]);   // R5

   AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));   // R9

endmodule

// File: tb/sim_mdio_mgmt_ctrl.sv
module sim_mdio_mgmt_ctrl;

   localparam int HD   = 2;
   localparam int PRE  = 32;
   localparam int NB   = PRE + 32;
   localparam int TLEN = NB * 2 * HD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int failures = 0;
   int rises = 0;
   int oe_rises = 0;
   int r9_bad = 0;
   logic [NB-1:0] cap = '0;
   logic [15:0]   resp = '0;
   logic          pm_mdc = 1'b0, pm_o = 1'b0, pm_oe = 1'b0;

   always #5 clk = ~clk;

   mdio_mgmt_ctrl #(.HALF_DIV(HD), .PRE_LEN(PRE)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model: capture driven bits on MDC rise
   initial forever begin
      @(posedge mdc);
      cap = {cap[NB-2:0], mdio_oe ? mdio_o : 1'b0};
      if (mdio_oe) oe_rises++;
      rises++;
   end

   // PHY model: present response bits after MDC falls
   initial forever begin
      @(negedge mdc);
      if (rises >= NB - 16 && rises < NB) mdio_i = resp[NB - 1 - rises];
      else mdio_i = 1'b1;
   end

   // R9 monitor: driven data may change only where MDC fell
   initial forever begin
      @(negedge clk);
      if (mdio_oe && pm_oe && (mdio_o != pm_o) && !(pm_mdc && !mdc)) r9_bad++;
      pm_mdc = mdc; pm_o = mdio_o; pm_oe = mdio_oe;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NB-1:0] frame(input logic [1:0] op, input logic [4:0] phy,
                                           input logic [4:0] rn, input logic [15:0] d);
      return {{PRE{1'b1}}, 2'b01, op, phy, rn, 2'b10, d};
   endfunction

   function automatic logic [31:0] word(input logic ie, input logic [1:0] op,
                                        input logic [4:0] phy, input logic [4:0] rn,
                                        input logic [15:0] d);
      return {2'b00, ie, 1'b0, op, phy, rn, d};
   endfunction

   task automatic issue(input logic [31:0] w);
      @(negedge clk);
      reg_wdata = w; reg_wr = 1'b1;
      rises = 0; oe_rises = 0; mdio_i = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_ready(output int lat);
      lat = 0;
      while (!reg_rdata[28] && lat < TLEN + 100) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      // R10 / R1 reset state
      chk(reg_rdata == 32'h0, "R1 reset word", reg_rdata, 0);
      chk({mdc, mdio_oe, irq} == 3'b000, "R10 reset pins", {mdc, mdio_oe, irq}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // write sweep
      for (int i = 0; i < 12; i++) begin
         logic [4:0] ph; logic [4:0] rn; logic [15:0] d; logic ie;
         ph = 5'((i * 7 + 1) % 32); rn = 5'((i * 11 + 3) % 32);
         d  = 16'hA5C3 ^ 16'(i * 16'h1357); ie = i[0];
         issue(word(ie, 2'b01, ph, rn, d));
         wait_ready(lat);
         chk(lat == TLEN, "R8 write length", lat, TLEN);
         chk(cap == frame(2'b01, ph, rn, d), "R2 write frame", cap, frame(2'b01, ph, rn, d));
         chk(oe_rises == NB, "R2 driven bits", oe_rises, NB);
         chk(reg_rdata == (word(ie, 2'b01, ph, rn, d) | 32'h1000_0000), "R1 R4 readback",
             reg_rdata, word(ie, 2'b01, ph, rn, d) | 32'h1000_0000);
         chk(irq == ie, "R5 irq follows enable", irq, ie);
         chk(!mdc && !mdio_oe, "R8 idle after frame", {mdc, mdio_oe}, 0);
      end

      // read sweep
      for (int i = 0; i < 12; i++) begin
         logic [4:0] ph; logic [4:0] rn; logic ie; logic [NB-1:0] ef;
         ph = 5'((i * 13 + 5) % 32); rn = 5'((i * 3 + 17) % 32); ie = ~i[0];
         resp = 16'h8001 ^ 16'(i * 16'h2F1B);
         ef = frame(2'b10, ph, rn, 16'h0);
         issue(word(ie, 2'b10, ph, rn, 16'hFFFF));
         wait_ready(lat);
         chk(lat == TLEN, "R8 read length", lat, TLEN);
         chk(cap[NB-1:18] == ef[NB-1:18], "R3 read header", cap[NB-1:18], ef[NB-1:18]);
         chk(oe_rises == NB - 18, "R3 release at turnaround", oe_rises, NB - 18);
         chk(reg_rdata[15:0] == resp, "R3 read data", reg_rdata[15:0], resp);
         chk(irq == ie, "R5 irq on read", irq, ie);
      end

      // R4 / R5: next command write clears ready and irq
      issue(word(1'b1, 2'b01, 5'd9, 5'd2, 16'h1234));
      wait_ready(lat);
      chk(irq == 1'b1, "R5 irq set", irq, 1);
      @(negedge clk);
      chk(irq == 1'b1, "R5 irq holds", irq, 1);
      issue(word(1'b0, 2'b10, 5'd4, 5'd1, 16'h0));
      chk(irq == 1'b0 && reg_rdata[28] == 1'b0, "R4 R5 cleared by command",
          {irq, reg_rdata[28]}, 0);
      wait_ready(lat);
      chk(irq == 1'b0, "R5 no irq without enable", irq, 0);

      // R6 reserved opcodes
      for (int k = 0; k < 2; k++) begin
         logic [1:0] op;
         op = (k == 0) ? 2'b00 : 2'b11;
         issue(word(1'b1, op, 5'd21, 5'd30, 16'hBEEF));
         chk(reg_rdata == (word(1'b1, op, 5'd21, 5'd30, 16'hBEEF) | 32'h1000_0000),
             "R6 reserved op ready at once", reg_rdata,
             word(1'b1, op, 5'd21, 5'd30, 16'hBEEF) | 32'h1000_0000);
         chk(irq == 1'b1, "R6 R5 irq on reserved op", irq, 1);
         repeat (20) @(negedge clk);
         chk(rises == 0 && !mdio_oe, "R6 no frame", rises, 0);
      end

      // R7 write during busy ignored
      issue(word(1'b0, 2'b01, 5'd3, 5'd7, 16'h0F0F));
      repeat (40) @(negedge clk);
      reg_wdata = word(1'b1, 2'b10, 5'd30, 5'd29, 16'hFFFF); reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      chk(reg_rdata[27:16] == {2'b01, 5'd3, 5'd7}, "R7 fields kept mid-frame",
          reg_rdata[27:16], {2'b01, 5'd3, 5'd7});
      wait_ready(lat);
      chk(cap == frame(2'b01, 5'd3, 5'd7, 16'h0F0F), "R7 frame unchanged", cap,
          frame(2'b01, 5'd3, 5'd7, 16'h0F0F));
      chk(reg_rdata == (word(1'b0, 2'b01, 5'd3, 5'd7, 16'h0F0F) | 32'h1000_0000),
          "R7 readback unchanged", reg_rdata,
          word(1'b0, 2'b01, 5'd3, 5'd7, 16'h0F0F) | 32'h1000_0000);
      chk(irq == 1'b0, "R7 enable from ignored write not taken", irq, 0);

      chk(r9_bad == 0, "R9 data changes only at MDC fall", r9_bad, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule